// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Rights

This block caches virtual-to-physical page mappings for a memory pipeline. Each request presents a virtual address and says whether it is a read or a write. The block compares the page-number part of the address against the tag of every stored entry in parallel. One cycle after the request it reports one of three outcomes. A hit gives the physical address. A miss means no valid entry carries that page number. A fault means a valid entry matched but its rights forbid the access.

After a miss, an external page-table walker writes the mapping through the fill port. The block chooses the slot for it: an empty slot first, then an entry that has not been used recently. Each entry keeps its own dirty and reference bits. A write that hits sets the dirty bit. Any hit sets the reference bit. A single flush input drops every mapping at once, for example on an address-space switch. The caller must not fill a page number that is already present.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, res_valid and fill_done are low and no entry is valid, so the first lookup reports a miss.
- R2: A lookup accepted in cycle N produces res_valid in cycle N+1 with exactly one of res_hit, res_miss and res_fault set; with res_valid low all three are low.
- R3: On a hit, res_paddr is the matching entry's physical page number in the upper bits, joined to the request's low OFF_W offset bits; when the outcome is not a hit, res_paddr is zero.
- R4: A read needs the entry's read right and a write needs its write right. A valid tag match without the needed right reports a fault and leaves the entry's dirty and reference bits unchanged.
- R5: A write hit sets the entry's dirty bit. res_dirty reports the matched entry's dirty bit as it stood before the access (on a hit or a fault) and is zero on a miss.
- R6: A fill accepted in cycle N raises fill_done in cycle N+1 with fill_idx naming the slot written. The slot is the lowest-index invalid entry if one exists. The new entry is valid, clean, with its reference bit set.
- R7: With all entries valid, the victim is the lowest-index entry whose reference bit is 0. If every reference bit is 1, all reference bits are cleared and entry 0 is replaced. A hit sets the entry's reference bit.
- R8: When fill_valid and lk_valid are high in the same cycle, the fill is performed and the lookup is dropped without a result.
- R9: flush clears every valid and reference bit in one cycle. A lookup or fill presented in the same cycle is ignored, and later lookups miss until new fills arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access (0 = read) |
| lk_vaddr | input | VA_W (32) | Virtual address of the lookup |
| fill_valid | input | 1 | Write a new mapping |
| fill_vpn | input | VPN_W (20) | Virtual page number of the new mapping |
| fill_ppn | input | PPN_W (18) | Physical page number of the new mapping |
| fill_rd | input | 1 | Read right of the new mapping |
| fill_wr | input | 1 | Write right of the new mapping |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | No valid matching entry |
| res_fault | output | 1 | Matching entry lacks the needed right |
| res_dirty | output | 1 | Dirty bit of the matched entry before the access |
| res_paddr | output | PA_W (30) | Physical address on a hit, else zero |
| fill_done | output | 1 | Fill completed |
| fill_idx | output | IDX_W (5) | Slot written by the completed fill |

## Verification
The hardest state to reach is a full buffer with a chosen mix of reference bits. Only then does the victim choice move off the invalid-slot path into the reference-bit search and the clear-all fallback. The stimulus first fills all 32 slots, which leaves every reference bit set. One more fill then forces the clear-all case. Selected read hits re-mark a few entries before further fills, so the search has to skip set bits to reach a cleared one. The rights faults and the dirty updates are driven on that same full table, and a flush at the end returns it to the empty-slot path.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes: consumers use the outcome encoding only inside the block.
package tlb_pkg;

    // Classification of one lookup
    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_FAULT = 2'd2
    } lk_outcome_e;

endpackage

// File: rtl/tlb_store.sv
// Entry storage: tag, frame, rights, dirty, reference and valid per slot.
// Assumes: fill and touch never arrive in the same cycle (the top drops
// the lookup when a fill is present); flush wins over both.
module tlb_store #(
    parameter int N     = 32,
    parameter int VPN_W = 20,
    parameter int PPN_W = 18,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    fill_en,
    input  logic [IDX_W-1:0]        fill_slot,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [PPN_W-1:0]        fill_ppn,
    input  logic                    fill_rd,
    input  logic                    fill_wr,
    input  logic                    ref_wipe,
    input  logic                    touch_en,
    input  logic [IDX_W-1:0]        touch_slot,
    input  logic                    touch_write,
    output logic [N-1:0]            vld,
    output logic [N-1:0]            refb,
    output logic [N-1:0]            dirty,
    output logic [N-1:0]            rd_ok,
    output logic [N-1:0]            wr_ok,
    output logic [N-1:0][VPN_W-1:0] tags,
    output logic [N-1:0][PPN_W-1:0] ppns
);

    // Status bits: valid, reference and dirty per entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            refb  <= '0;
            dirty <= '0;
        end else if (flush) begin
            vld  <= '0;
            refb <= '0;
        end else if (fill_en) begin
            if (ref_wipe) begin
                refb <= '0;
            end
            vld[fill_slot]   <= 1'b1;
            refb[fill_slot]  <= 1'b1;
            dirty[fill_slot] <= 1'b0;
        end else if (touch_en) begin
            refb[touch_slot] <= 1'b1;
            if (touch_write) begin
                dirty[touch_slot] <= 1'b1;
            end
        end
    end

    // Mapping payload: written only by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags  <= '0;
            ppns  <= '0;
            rd_ok <= '0;
            wr_ok <= '0;
        end else if (fill_en && !flush) begin
            tags[fill_slot]  <= fill_vpn;
            ppns[fill_slot]  <= fill_ppn;
            rd_ok[fill_slot] <= fill_rd;
            wr_ok[fill_slot] <= fill_wr;
        end
    end

endmodule

// File: rtl/tlb_match.sv
// Parallel tag compare and selection of the matching entry's fields.
// Assumes: at most one valid entry carries a given page number.
module tlb_match #(
    parameter int N     = 32,
    parameter int VPN_W = 20,
    parameter int PPN_W = 18,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [VPN_W-1:0]        vpn,
    input  logic                    is_write,
    input  logic [N-1:0]            vld,
    input  logic [N-1:0]            dirty,
    input  logic [N-1:0]            rd_ok,
    input  logic [N-1:0]            wr_ok,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [N-1:0][PPN_W-1:0] ppns,
    output logic                    found,
    output logic                    permit,
    output logic                    sel_dirty,
    output logic [IDX_W-1:0]        sel_idx,
    output logic [PPN_W-1:0]        sel_ppn
);

    logic [N-1:0] eq_vec;

    // One comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq_vec[g] = vld[g] && (tags[g] == vpn);
    end

    // OR-select the fields of the (single) matching slot
    always_comb begin
        found     = |eq_vec;
        permit    = 1'b0;
        sel_dirty = 1'b0;
        sel_idx   = '0;
        sel_ppn   = '0;
        for (int i = 0; i < N; i++) begin
            if (eq_vec[i]) begin
                permit    = permit | (is_write ? wr_ok[i] : rd_ok[i]);
                sel_dirty = sel_dirty | dirty[i];
                sel_idx   = sel_idx | IDX_W'(i);
                sel_ppn   = sel_ppn | ppns[i];
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Replacement choice: lowest invalid slot, else lowest slot with a clear
// reference bit, else slot 0 together with a request to wipe all bits.
// Assumes: the wipe is applied by the storage in the fill cycle.
module tlb_victim #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     refb,
    output logic [IDX_W-1:0] slot,
    output logic             wipe
);

    logic             have_free;
    logic             have_cold;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;

    // Priority search, downward so the lowest index is kept last
    always_comb begin
        have_free = 1'b0;
        have_cold = 1'b0;
        free_idx  = '0;
        cold_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (!refb[i]) begin
                have_cold = 1'b1;
                cold_idx  = IDX_W'(i);
            end
        end
    end

    // Final pick and clear-all fallback
    always_comb begin
        wipe = 1'b0;
        if (have_free) begin
            slot = free_idx;
        end else if (have_cold) begin
            slot = cold_idx;
        end else begin
            slot = '0;
            wipe = 1'b1;
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
// Fully associative translation buffer top level.
// Lookup decode is combinational, results are registered one cycle later.
// Priority within a cycle: flush, then fill, then lookup.
// Assumes: callers never fill a page number already present.
module xlat_tlb #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_fault,
    output logic             res_dirty,
    output logic [PA_W-1:0]  res_paddr,
    output logic             fill_done,
    output logic [IDX_W-1:0] fill_idx
);

    import tlb_pkg::*;

    logic [ENTRIES-1:0]            vld_w;
    logic [ENTRIES-1:0]            ref_w;
    logic [ENTRIES-1:0]            dirty_w;
    logic [ENTRIES-1:0]            rd_w;
    logic [ENTRIES-1:0]            wr_w;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_w;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_w;

    logic             do_fill;
    logic             do_look;
    logic             m_found;
    logic             m_permit;
    logic             m_dirty;
    logic [IDX_W-1:0] m_idx;
    logic [PPN_W-1:0] m_ppn;
    logic [IDX_W-1:0] v_slot;
    logic             v_wipe;
    lk_outcome_e      outcome;

    // Accept rules for this cycle
    assign do_fill = fill_valid && !flush;
    assign do_look = lk_valid && !fill_valid && !flush;

    tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_en    (do_fill),
        .fill_slot  (v_slot),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .fill_rd    (fill_rd),
        .fill_wr    (fill_wr),
        .ref_wipe   (v_wipe),
        .touch_en   (do_look && outcome == LK_HIT),
        .touch_slot (m_idx),
        .touch_write(lk_write),
        .vld        (vld_w),
        .refb       (ref_w),
        .dirty      (dirty_w),
        .rd_ok      (rd_w),
        .wr_ok      (wr_w),
        .tags       (tag_w),
        .ppns       (ppn_w)
    );

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
        .vpn      (lk_vaddr[VA_W-1:OFF_W]),
        .is_write (lk_write),
        .vld      (vld_w),
        .dirty    (dirty_w),
        .rd_ok    (rd_w),
        .wr_ok    (wr_w),
        .tags     (tag_w),
        .ppns     (ppn_w),
        .found    (m_found),
        .permit   (m_permit),
        .sel_dirty(m_dirty),
        .sel_idx  (m_idx),
        .sel_ppn  (m_ppn)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .vld (vld_w),
        .refb(ref_w),
        .slot(v_slot),
        .wipe(v_wipe)
    );

    // Classify the current lookup
    always_comb begin
        if (!m_found) begin
            outcome = LK_MISS;
        end else if (m_permit) begin
            outcome = LK_HIT;
        end else begin
            outcome = LK_FAULT;
        end
    end

    // Register the lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_fault <= 1'b0;
            res_dirty <= 1'b0;
            res_paddr <= '0;
        end else begin
            res_valid <= do_look;
            res_hit   <= do_look && outcome == LK_HIT;
            res_miss  <= do_look && outcome == LK_MISS;
            res_fault <= do_look && outcome == LK_FAULT;
            res_dirty <= do_look && m_found && m_dirty;
            if (do_look && outcome == LK_HIT) begin
                res_paddr <= {m_ppn, lk_vaddr[OFF_W-1:0]};
            end else begin
                res_paddr <= '0;
            end
        end
    end

    // Register the fill completion and its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_done <= 1'b0;
            fill_idx  <= '0;
        end else begin
            fill_done <= do_fill;
            fill_idx  <= do_fill ? v_slot : '0;
        end
    end

endmodule

// File: rtl/tlb_checker.sv
// Temporal checks for xlat_tlb, attached with bind.
module tlb_checker #(
    parameter int N     = 32,
    parameter int OFF_W = 12,
    parameter int VA_W  = 32,
    parameter int PA_W  = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            fill_valid,
    input logic            res_valid,
    input logic            res_hit,
    input logic            res_miss,
    input logic            res_fault,
    input logic [PA_W-1:0] res_paddr,
    input logic            fill_done,
    input logic [N-1:0]    vld
);

    // R2: exactly one outcome with a result
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_fault}) == 1);

    // R2: no outcome flag without a result
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_fault));

    // R2: accepted lookup yields a result next cycle
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !fill_valid && !flush) |=> res_valid);

    // R3: offset passes through on a hit
    a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !fill_valid && !flush) |=>
            (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R3: zero address unless hit
    a_r3_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_paddr == '0);

    // R6: accepted fill completes next cycle
    a_r6_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> fill_done);

    // R8 and R9: fill or flush suppresses the lookup result
    a_r8_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || flush) |=> !res_valid);

    // R9: flush empties the table
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> vld == '0);

endmodule

bind xlat_tlb tlb_checker #(
    .N    (ENTRIES),
    .OFF_W(OFF_W),
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .fill_valid(fill_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_fault (res_fault),
    .res_paddr (res_paddr),
    .fill_done (fill_done),
    .vld       (vld_w)
);

// File: tb/xlat_tlb_tb.sv
// Scoreboard bench: driver tasks queue expected items from a model built
// on the requirements; a negedge monitor compares them with the outputs.
module xlat_tlb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 32;
    localparam int VPN_W = 20;
    localparam int PPN_W = 18;
    localparam int OFF_W = 12;
    localparam int IDX_W = 5;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct {
        bit              is_fill;
        bit              hit;
        bit              miss;
        bit              fault;
        bit              dirty;
        bit [PA_W-1:0]   paddr;
        bit [IDX_W-1:0]  idx;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             lk_valid = 1'b0;
    logic             lk_write = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_rd = 1'b0;
    logic             fill_wr = 1'b0;
    logic             res_valid;
    logic             res_hit;
    logic             res_miss;
    logic             res_fault;
    logic             res_dirty;
    logic [PA_W-1:0]  res_paddr;
    logic             fill_done;
    logic [IDX_W-1:0] fill_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t q[$];

    // Reference model state
    bit             m_vld [N];
    bit             m_ref [N];
    bit             m_dirty [N];
    bit             m_rd [N];
    bit             m_wr [N];
    bit [VPN_W-1:0] m_tag [N];
    bit [PPN_W-1:0] m_ppn [N];

    xlat_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_fault(res_fault), .res_dirty(res_dirty), .res_paddr(res_paddr),
        .fill_done(fill_done), .fill_idx(fill_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model: victim choice per R6 and R7
    function automatic int pick_victim(output bit wipe);
        wipe = 1'b0;
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < N; i++) if (!m_ref[i]) return i;
        wipe = 1'b1;
        return 0;
    endfunction

    // Model fill; returns the expected slot
    function automatic int model_fill(input bit [VPN_W-1:0] vpn,
                                      input bit [PPN_W-1:0] ppn,
                                      input bit r, input bit w);
        bit wipe;
        int s;
        s = pick_victim(wipe);
        if (wipe) for (int i = 0; i < N; i++) m_ref[i] = 1'b0;
        m_vld[s] = 1'b1; m_ref[s] = 1'b1; m_dirty[s] = 1'b0;
        m_tag[s] = vpn;  m_ppn[s] = ppn; m_rd[s] = r; m_wr[s] = w;
        return s;
    endfunction

    // Driver: fill request, optionally with a colliding lookup (R8)
    task automatic do_fill(input bit [VPN_W-1:0] vpn, input bit [PPN_W-1:0] ppn,
                           input bit r, input bit w, input bit with_look,
                           input string tag);
        exp_t e;
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_rd = r; fill_wr = w;
        lk_valid = with_look; lk_write = 1'b0; lk_vaddr = {vpn, 12'h0};
        e = '{is_fill: 1'b1, hit: 0, miss: 0, fault: 0, dirty: 0, paddr: '0,
              idx: IDX_W'(model_fill(vpn, ppn, r, w)), tag: tag};
        q.push_back(e);
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        if (with_look) check(!res_valid, "R8", "dropped lookup result",
                             longint'(res_valid), 0);
    endtask

    // Driver: lookup request with the expected outcome from the model
    task automatic do_look(input bit [VPN_W-1:0] vpn, input bit [OFF_W-1:0] off,
                           input bit wr, input string tag);
        exp_t e;
        int hit_i;
        hit_i = -1;
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == vpn) hit_i = i;
        e = '{is_fill: 1'b0, hit: 0, miss: 0, fault: 0, dirty: 0, paddr: '0,
              idx: '0, tag: tag};
        if (hit_i < 0) begin
            e.miss = 1'b1;
        end else begin
            e.dirty = m_dirty[hit_i];
            if (wr ? m_wr[hit_i] : m_rd[hit_i]) begin
                e.hit = 1'b1;
                e.paddr = {m_ppn[hit_i], off};
                m_ref[hit_i] = 1'b1;
                if (wr) m_dirty[hit_i] = 1'b1;
            end else begin
                e.fault = 1'b1;
            end
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, off};
        q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Driver: flush, optionally with a lookup in the same cycle (R9)
    task automatic do_flush(input bit with_look);
        @(negedge clk);
        flush = 1'b1; lk_valid = with_look; lk_vaddr = '0;
        for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_ref[i] = 1'b0; end
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0;
        check(!res_valid, "R9", "no result under flush", longint'(res_valid), 0);
    endtask

    // Monitor: compare outputs with queued expectations
    always @(negedge clk) begin
        if (rst_n && (res_valid || fill_done)) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.is_fill) begin
                    check(fill_done && !res_valid, e.tag, "fill_done",
                          longint'(fill_done), 1);
                    check(fill_idx == e.idx, e.tag, "fill_idx",
                          longint'(fill_idx), longint'(e.idx));
                end else begin
                    check(res_valid && res_hit == e.hit && res_miss == e.miss &&
                          res_fault == e.fault, e.tag, "outcome hit/miss/fault",
                          longint'({res_hit, res_miss, res_fault}),
                          longint'({e.hit, e.miss, e.fault}));
                    check(res_paddr == e.paddr, e.tag, "res_paddr",
                          longint'(res_paddr), longint'(e.paddr));
                    check(res_dirty == e.dirty, e.tag, "res_dirty",
                          longint'(res_dirty), longint'(e.dirty));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
            m_tag[i] = '0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset, empty table
        check(!res_valid && !fill_done, "R1", "reset outputs",
              longint'({res_valid, fill_done}), 0);
        do_look(20'h00100, 12'h010, 1'b0, "R1");

        // R6: fill every slot in index order
        for (int i = 0; i < N; i++)
            do_fill(20'h00100 + 20'(i), 18'h02000 + 18'(i),
                    i != 5, (i % 2) == 0, 1'b0, "R6");

        // R3: hits with several offsets
        do_look(20'h00100, 12'hABC, 1'b0, "R3");
        do_look(20'h00107, 12'h001, 1'b0, "R3");
        do_look(20'h0011F, 12'hFFF, 1'b0, "R3");
        do_look(20'h00999, 12'h123, 1'b0, "R2");

        // R4: rights faults leave state alone
        do_look(20'h00105, 12'h004, 1'b0, "R4");
        do_look(20'h00103, 12'h008, 1'b1, "R4");
        do_look(20'h00103, 12'h008, 1'b0, "R4");

        // R5: write hit marks dirty, seen on the following access
        do_look(20'h00104, 12'h020, 1'b1, "R5");
        do_look(20'h00104, 12'h024, 1'b0, "R5");
        do_look(20'h00104, 12'h028, 1'b1, "R5");

        // R7: all reference bits set -> wipe and replace slot 0
        do_fill(20'h00500, 18'h03000, 1'b1, 1'b1, 1'b0, "R7");
        do_look(20'h00100, 12'h000, 1'b0, "R7");
        do_fill(20'h00501, 18'h03001, 1'b1, 1'b1, 1'b0, "R7");
        do_look(20'h00103, 12'h030, 1'b0, "R7");
        do_fill(20'h00502, 18'h03002, 1'b1, 1'b1, 1'b0, "R7");
        do_fill(20'h00503, 18'h03003, 1'b1, 1'b1, 1'b0, "R7");
        do_look(20'h00503, 12'h040, 1'b1, "R7");

        // R8: fill and lookup together
        do_fill(20'h00504, 18'h03004, 1'b1, 1'b0, 1'b1, "R8");
        do_look(20'h00504, 12'h050, 1'b0, "R8");

        // R9: flush, then everything misses and fills restart at slot 0
        do_flush(1'b0);
        do_look(20'h00500, 12'h060, 1'b0, "R9");
        do_flush(1'b1);
        do_fill(20'h00777, 18'h03777, 1'b1, 1'b1, 1'b0, "R9");
        do_look(20'h00777, 12'h070, 1'b0, "R9");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2", "all expected items seen",
              longint'(q.size()), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule